// File: doc/BRIEF.md
# Chained DMA Address and Byte Counter

This block keeps the live memory address and remaining byte count of one DMA channel. Behind them sits a hidden pair of "next" registers, so that software can queue the following transfer while the current one is still running. A peripheral raises a request. The block acknowledges it in the same cycle when the channel is active. Each acknowledged transfer moves the address up by one and, when counting is enabled, moves the count down by one.

When the count reaches zero, the block sets a sticky terminal-count flag. If chaining is enabled and a fresh next address has been queued, the block swaps the next pair into the live pair in that same cycle. If no next address has been queued, the channel stalls. It ignores requests until software writes a next address or turns chaining off. An interrupt output combines the terminal-count and error flags under an enable bit and a terminal-count mask bit.

Top module: `dma_chain_engine`

## Requirements
- R1: With chaining on (control bit 5), a write to the address register (select 1) lands in the hidden next address and leaves the live address unchanged. With chaining off, it writes the live address directly.
- R2: With chaining on, a write to the count register (select 2) lands in the hidden next count and leaves the live count unchanged. With chaining off, it writes the live count directly.
- R3: Each cycle with `req` high and `dma_on` high raises `ack` combinationally. At the following edge the address increments by 1, and the count decrements by 1 if counting is enabled (control bit 3). With counting off, the count does not change and never expires.
- R4: When an acknowledged transfer takes the count from 1 to 0 with chaining on, and a next-address write has occurred since the previous expiry or reload, the live address and live count take the next values at that same edge.
- R5: When the count expires with chaining on and no next address has been queued, the channel stalls. While stalled, `dma_on` reads 0 and requests get no `ack`.
- R6: A next-address write to a stalled channel sets a pending flag. At the following edge the next pair is copied into the live pair and the stall ends, before any `ack`. Clearing chaining also ends a stall.
- R7: Each expiry sets the sticky `tc_pend`. Writing the control register (select 0) with bit 8 set clears it. A set in the same cycle wins over the clear.
- R8: `irq` is high exactly when the interrupt-enable bit (control bit 0) is set and either `tc_pend` is set with the mask bit (control bit 4) clear, or `err_pend` is set.
- R9: `to_mem` follows control bit 2, where 1 means the transfer writes to memory and 0 means it reads from memory.
- R10: With chaining off, expiry leaves the count at 0. `dma_on` then stays 0 until the live count is rewritten. `dma_on` also requires the enable bit (control bit 1).
- R11: A high `periph_err` sets the sticky `err_pend`. Writing the control register with bit 9 set clears it.
- R12: After reset, every output, register and flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 control, 1 address, 2 count |
| host_wdata | input | AW | Host write data |
| req | input | 1 | Peripheral transfer request |
| periph_err | input | 1 | Peripheral error pulse |
| ack | output | 1 | Transfer acknowledge |
| cur_addr | output | AW | Live address |
| cur_count | output | CW | Live byte count |
| dma_on | output | 1 | Channel active status |
| to_mem | output | 1 | Direction, 1 = toward memory |
| tc_pend | output | 1 | Sticky terminal-count flag |
| err_pend | output | 1 | Sticky error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs four request patterns, each of which separates a different set of faults.

- **Continuous request, chaining off.** This shows whether the count limit stops the channel at exactly zero.
- **Continuous request across two expiries, chaining on.** The first expiry has a queued descriptor and the second has none. This separates a same-edge reload from a stall, and it exposes any acknowledge given while stalled.
- **Restart by next-address write, and exit by clearing chaining.** This shows whether the live pair is refilled before the first acknowledge.
- **Request with counting off and error pulses.** This shows whether the count stays frozen, and it tests the error and mask terms of the interrupt separately from the terminal-count term.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int CTL_IRQ_EN  = 0;
    localparam int CTL_DMA_EN  = 1;
    localparam int CTL_TO_MEM  = 2;
    localparam int CTL_CNT_EN  = 3;
    localparam int CTL_TC_MASK = 4;
    localparam int CTL_AUTO_EN = 5;
    localparam int STS_TC_BIT  = 8;
    localparam int STS_ERR_BIT = 9;
    localparam int CSR_BITS    = 10;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic auto_en;
        logic tc_mask;
        logic cnt_en;
        logic to_mem;
        logic dma_en;
        logic irq_en;
    } ctrl_t;

endpackage

// File: rtl/dma_csr.sv
module dma_csr
    import dma_chain_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [1:0]          sel,
    input  logic [CSR_BITS-1:0] wdata,
    input  logic                expire,
    input  logic                perr,
    output ctrl_t               ctrl,
    output logic                tc_q,
    output logic                err_q,
    output logic                irq
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  tc;
        logic  err;
    } csr_state_t;

    csr_state_t s_d, s_q;
    logic       csr_wr;

    always_comb begin
        s_d    = s_q;
        csr_wr = we && (sel == SEL_CTRL);
        if (csr_wr) begin
            s_d.ctrl.irq_en  = wdata[CTL_IRQ_EN];
            s_d.ctrl.dma_en  = wdata[CTL_DMA_EN];
            s_d.ctrl.to_mem  = wdata[CTL_TO_MEM];
            s_d.ctrl.cnt_en  = wdata[CTL_CNT_EN];
            s_d.ctrl.tc_mask = wdata[CTL_TC_MASK];
            s_d.ctrl.auto_en = wdata[CTL_AUTO_EN];
            if (wdata[STS_TC_BIT])  s_d.tc  = 1'b0;
            if (wdata[STS_ERR_BIT]) s_d.err = 1'b0;
        end
        if (expire) s_d.tc  = 1'b1;
        if (perr)   s_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl  = s_q.ctrl;
    assign tc_q  = s_q.tc;
    assign err_q = s_q.err;
    assign irq   = s_q.ctrl.irq_en && ((s_q.tc && !s_q.ctrl.tc_mask) || s_q.err);

    // R7: terminal-count flag survives until a write-one-to-clear
    p_tc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_q && !(we && sel == SEL_CTRL && wdata[STS_TC_BIT])) |=> tc_q);

    // R11: error flag rises after an error pulse
    p_err_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        perr |=> err_q);

endmodule

// File: rtl/dma_xfer_core.sv
module dma_xfer_core
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] wdata,
    input  logic          dma_en,
    input  logic          cnt_en,
    input  logic          auto_en,
    input  logic          req,
    output logic          ack,
    output logic          dma_on,
    output logic          expire,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic [AW-1:0] naddr;
        logic [CW-1:0] ncnt;
        logic          nflag;
        logic          stall;
    } core_state_t;

    core_state_t s_d, s_q;

    always_comb begin
        dma_on = dma_en && !s_q.stall && !(cnt_en && (s_q.cnt == '0));
        ack    = req && dma_on;
        expire = ack && cnt_en && (s_q.cnt == CW'(1));
        s_d    = s_q;

        if (ack) begin
            s_d.addr = s_q.addr + AW'(1);
            if (cnt_en) s_d.cnt = s_q.cnt - CW'(1);
        end

        if (expire && auto_en) begin
            if (s_q.nflag) begin
                s_d.addr  = s_q.naddr;
                s_d.cnt   = s_q.ncnt;
                s_d.nflag = 1'b0;
            end else begin
                s_d.stall = 1'b1;
            end
        end

        if (s_q.stall) begin
            if (!auto_en) begin
                s_d.stall = 1'b0;
            end else if (s_q.nflag) begin
                s_d.addr  = s_q.naddr;
                s_d.cnt   = s_q.ncnt;
                s_d.nflag = 1'b0;
                s_d.stall = 1'b0;
            end
        end

        if (we && sel == SEL_ADDR) begin
            if (auto_en) begin
                s_d.naddr = wdata;
                s_d.nflag = 1'b1;
            end else begin
                s_d.addr = wdata;
            end
        end
        if (we && sel == SEL_COUNT) begin
            if (auto_en) s_d.ncnt = wdata[CW-1:0];
            else         s_d.cnt  = wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr  = s_q.addr;
    assign count = s_q.cnt;

    // R5: a stalled channel never acknowledges
    p_stall_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stall |-> !ack);

    // R3: a plain transfer steps the address by one
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire && !we && !s_q.stall) |=> addr == $past(addr) + AW'(1));

    // R4: queued descriptor is swapped in at the expiring edge
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && auto_en && s_q.nflag && !we) |=>
        (addr == $past(s_q.naddr)) && (count == $past(s_q.ncnt)));

    // R1: redirected address write leaves the live address alone
    p_redirect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_ADDR && auto_en && !ack && !s_q.stall) |=> $stable(addr));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [1:0]    host_sel,
    input  logic [AW-1:0] host_wdata,
    input  logic          req,
    input  logic          periph_err,
    output logic          ack,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_count,
    output logic          dma_on,
    output logic          to_mem,
    output logic          tc_pend,
    output logic          err_pend,
    output logic          irq
);

    ctrl_t ctrl;
    logic  expire;

    dma_csr u_csr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (host_we),
        .sel    (host_sel),
        .wdata  (host_wdata[CSR_BITS-1:0]),
        .expire (expire),
        .perr   (periph_err),
        .ctrl   (ctrl),
        .tc_q   (tc_pend),
        .err_q  (err_pend),
        .irq    (irq)
    );

    dma_xfer_core #(.AW(AW), .CW(CW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (host_we),
        .sel     (host_sel),
        .wdata   (host_wdata),
        .dma_en  (ctrl.dma_en),
        .cnt_en  (ctrl.cnt_en),
        .auto_en (ctrl.auto_en),
        .req     (req),
        .ack     (ack),
        .dma_on  (dma_on),
        .expire  (expire),
        .addr    (cur_addr),
        .count   (cur_count)
    );

    assign to_mem = ctrl.to_mem;

    // R8: no interrupt without the enable bit
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.irq_en |-> !irq);

    // R10: an exhausted counted channel is inactive
    p_count_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.cnt_en && cur_count == '0) |-> !dma_on);

endmodule

// File: tb/tb_dma_chain_engine.sv
`timescale 1ns/1ps
module tb_dma_chain_engine;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_we = 1'b0;
    logic [1:0]    host_sel = 2'd0;
    logic [AW-1:0] host_wdata = '0;
    logic          req = 1'b0;
    logic          periph_err = 1'b0;
    logic          ack, dma_on, to_mem, tc_pend, err_pend, irq;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dma_chain_engine #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .req(req), .periph_err(periph_err),
        .ack(ack), .cur_addr(cur_addr), .cur_count(cur_count), .dma_on(dma_on),
        .to_mem(to_mem), .tc_pend(tc_pend), .err_pend(err_pend), .irq(irq)
    );

    // behavioural reference state
    longint m_addr, m_cnt, m_naddr, m_ncnt;
    bit m_flag, m_stall, m_tc, m_err;
    bit c_irq, c_dma, c_mem, c_cnt, c_mask, c_auto;

    function automatic bit m_on();
        return c_dma && !m_stall && !(c_cnt && m_cnt == 0);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_cnt = 0; m_naddr = 0; m_ncnt = 0;
            m_flag = 0; m_stall = 0; m_tc = 0; m_err = 0;
            {c_irq, c_dma, c_mem, c_cnt, c_mask, c_auto} = '0;
        end else begin
            bit take, fin, was_stall, was_flag, auto_now;
            take = req && m_on();
            fin = take && c_cnt && m_cnt == 1;
            was_stall = m_stall;
            was_flag = m_flag;
            auto_now = c_auto;
            if (take) begin
                m_addr = (m_addr + 1) % (64'd1 << AW);
                if (c_cnt) m_cnt = m_cnt - 1;
            end
            if (fin) m_tc = 1;
            if (fin && auto_now) begin
                if (was_flag) begin m_addr = m_naddr; m_cnt = m_ncnt; m_flag = 0; end
                else m_stall = 1;
            end
            if (was_stall) begin
                if (!auto_now) m_stall = 0;
                else if (was_flag) begin
                    m_addr = m_naddr; m_cnt = m_ncnt; m_flag = 0; m_stall = 0;
                end
            end
            if (host_we && host_sel == 1) begin
                if (auto_now) begin m_naddr = host_wdata; m_flag = 1; end
                else m_addr = host_wdata;
            end
            if (host_we && host_sel == 2) begin
                if (auto_now) m_ncnt = host_wdata[CW-1:0];
                else m_cnt = host_wdata[CW-1:0];
            end
            if (host_we && host_sel == 0) begin
                c_irq = host_wdata[0]; c_dma = host_wdata[1]; c_mem = host_wdata[2];
                c_cnt = host_wdata[3]; c_mask = host_wdata[4]; c_auto = host_wdata[5];
                if (host_wdata[8]) m_tc = 0;
                if (host_wdata[9]) m_err = 0;
                if (fin) m_tc = 1;
            end
            if (periph_err) m_err = 1;
        end
    end

    // compare against the model every cycle, mid-period
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 addr", cur_addr, m_addr);
            chk("R3 count", cur_count, m_cnt);
            chk("R5 dma_on", dma_on, m_on());
            chk("R5 ack", ack, req && m_on());
            chk("R7 tc_pend", tc_pend, m_tc);
            chk("R11 err_pend", err_pend, m_err);
            chk("R8 irq", irq, c_irq && ((m_tc && !c_mask) || m_err));
            chk("R9 to_mem", to_mem, c_mem);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
        host_we = 1'b1; host_sel = s; host_wdata = d;
        tick(1);
        host_we = 1'b0;
    endtask

    localparam logic [AW-1:0] IRQ = 1, DMA = 2, MEM = 4, CNT = 8, MSK = 16, AUT = 32;
    localparam logic [AW-1:0] TCC = 256, ERC = 512;

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R12: reset state
        chk("R12 reset addr", cur_addr, 0);
        chk("R12 reset count", cur_count, 0);
        chk("R12 reset flags", {dma_on, tc_pend, err_pend, irq, ack}, 0);

        // chaining off, counted run
        wr(0, IRQ | DMA | MEM | CNT);
        wr(1, 32'h100);
        wr(2, 3);
        req = 1'b1;
        tick(5);
        req = 1'b0;
        chk("R10 stop addr", cur_addr, 32'h103);
        chk("R10 stop count", cur_count, 0);
        chk("R10 inactive", dma_on, 0);
        chk("R7 tc set", tc_pend, 1);
        chk("R8 irq tc", irq, 1);
        chk("R9 dir", to_mem, 1);
        wr(0, TCC | IRQ | DMA | CNT | MSK);
        chk("R7 tc cleared", tc_pend, 0);

        // load live pair, then enable chaining and queue
        wr(1, 32'h200);
        wr(2, 2);
        wr(0, IRQ | DMA | CNT | MSK | AUT);
        wr(1, 32'h300);
        wr(2, 3);
        chk("R1 live addr kept", cur_addr, 32'h200);
        chk("R2 live count kept", cur_count, 2);
        req = 1'b1;
        tick(2);
        chk("R4 reload addr", cur_addr, 32'h300);
        chk("R4 reload count", cur_count, 3);
        chk("R8 masked tc", irq, 0);
        tick(3);
        chk("R5 stalled", dma_on, 0);
        tick(2);
        chk("R5 held addr", cur_addr, 32'h303);
        wr(2, 1);
        wr(1, 32'h400);
        chk("R6 no ack yet", ack, 0);
        tick(1);
        chk("R6 restart addr", cur_addr, 32'h400);
        chk("R6 restart count", cur_count, 1);
        tick(1);
        req = 1'b0;
        chk("R5 stall again", cur_addr, 32'h401);
        wr(0, IRQ | DMA | CNT);
        wr(2, 4);
        req = 1'b1;
        tick(6);
        req = 1'b0;
        chk("R6 resumed after clear", cur_addr, 32'h405);

        // counting off, error path
        wr(0, TCC | IRQ | DMA);
        req = 1'b1;
        tick(3);
        req = 1'b0;
        chk("R3 uncounted addr", cur_addr, 32'h408);
        chk("R3 uncounted count", cur_count, 0);
        periph_err = 1'b1;
        tick(1);
        periph_err = 1'b0;
        chk("R11 err set", err_pend, 1);
        chk("R8 irq err", irq, 1);
        wr(0, ERC | IRQ);
        chk("R11 err cleared", err_pend, 0);
        tick(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule